// File: doc/BRIEF.md
# Quick Add/Subtract Bus Step Sequencer

This block schedules the bus activity of a processor's quick add and quick subtract group: the instructions that add or subtract a small constant carried in the opcode. It handles four destination kinds: a data register, an address register, a memory operand reached through an address register, and the same memory operand with the register stepped forward afterwards. The arithmetic is done elsewhere. This block only says, cycle by cycle, which bus step is wanted, at which address, on which byte lanes, and when the datapath should perform the operation.

A job is accepted on a start strobe when the sequencer is idle. At that moment the size, addressing mode, register number and the register's current address value are captured. Each bus step waits for the acknowledge input before moving on. Internal steps advance by themselves. A job that asks for an unsupported mode or size, or for a word or long access at an odd address, is refused in the same cycle.

Top module: `quickop_seq`

## Requirements
- R1: With mode 0 (data register) and size 0 (byte) or 1 (word), the job is one prefetch step (step code 1). `operate` is high in the cycle that prefetch is acknowledged, and the block is idle afterwards.
- R2: With mode 0 at size 2 (long), or with mode 1 (address register) at any size, the job is a prefetch with `operate` high on its acknowledged cycle. One internal step (code 2) follows. It lasts exactly one cycle whatever `ack` does.
- R3: With mode 2 (indirect) or mode 3 (post-increment) at byte or word size, the order is as follows. A read-low step (code 4) at the captured address comes first. A prefetch follows. Then there is one cycle with step code 0 and `operate` high. Last comes a write-low step (code 6) at the same address.
- R4: With mode 2 or 3 at long size, the order is as follows. One address-copy cycle (code 0) comes first. A read-high step (code 3) at the captured address follows, then a read-low step at address+2, then a prefetch. Then comes an operate cycle (code 0, `operate` high). The last two steps are a write-low at address+2 and a write-high (code 5) at the address.
- R5: In mode 3 only, after the final write one cycle has `inc_req` high, with `inc_reg` equal to the captured register number and `inc_amt` equal to 1, 2 or 4 for byte, word or long. Mode 2 never raises `inc_req`.
- R6: `reject` is high in the cycle of an idle start whose mode is 4 to 7, whose size is 3, or which is a memory mode at word or long size with address bit 0 set. Such a start leaves `busy` low.
- R7: A bus step (codes 1, 3, 4, 5, 6) repeats, with the same address, in every cycle where `ack` is low. Non-bus cycles (codes 0 and 2) never wait.
- R8: `busy` is high from the cycle after an accepted start until the cycle after the last step. A start while busy is ignored: no `reject`, and no change to the running sequence.
- R9: On data steps `lane` is 2'b10 for a byte at an even address, 2'b01 for a byte at an odd address and 2'b11 for word and long. It is 2'b00 on every other step.
- R10: After reset, `busy`, `operate` and `inc_req` are low and `step` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe for a new job |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| mode | input | 3 | Destination mode: 0 data reg, 1 address reg, 2 indirect, 3 post-increment |
| regno | input | 3 | Destination register number |
| base_addr | input | 24 | Current value of the addressing register |
| ack | input | 1 | Bus step acknowledge |
| busy | output | 1 | Job in progress |
| step | output | 3 | Step code for this cycle |
| addr | output | 24 | Address for data steps |
| lane | output | 2 | Byte lane select {upper, lower} |
| operate | output | 1 | Perform the arithmetic this cycle |
| inc_req | output | 1 | Request to step the address register |
| inc_reg | output | 3 | Register to step |
| inc_amt | output | 3 | Amount to add to the register |
| reject | output | 1 | Start refused |

## Verification
A wrong state would show up on `step` as a missing, repeated or reordered code. It would appear at the first cycle the state is wrong, so the bench compares every advancing cycle against an expected list built from the size, mode and address of the job. A wrong context capture would show as a bad address, lane or increment amount on the next data or increment step. Random acknowledge stalls make a missed hold visible as a step that changes code or address while `ack` is low.

// File: rtl/quickop_pkg.sv
package quickop_pkg;
  typedef enum logic [2:0] {
    STEP_NONE     = 3'd0,
    STEP_PREFETCH = 3'd1,
    STEP_INTERNAL = 3'd2,
    STEP_RD_HI    = 3'd3,
    STEP_RD_LO    = 3'd4,
    STEP_WR_HI    = 3'd5,
    STEP_WR_LO    = 3'd6
  } step_e;

  typedef enum logic [3:0] {
    S_IDLE, S_EACOPY, S_RDHI, S_RDLO, S_PF, S_INT, S_OPR, S_WRLO, S_WRHI, S_INC
  } state_e;

  typedef enum logic [1:0] {
    K_REG_SHORT = 2'd0,
    K_REG_LONG  = 2'd1,
    K_MEM       = 2'd2
  } kind_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam logic [2:0] MD_DREG = 3'd0;
  localparam logic [2:0] MD_AREG = 3'd1;
  localparam logic [2:0] MD_IND  = 3'd2;
  localparam logic [2:0] MD_POST = 3'd3;
endpackage

// File: rtl/quickop_decode.sv
module quickop_decode
  import quickop_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [1:0]        size,
  input  logic [2:0]        mode,
  input  logic              addr_lsb,
  output logic              valid,
  output kind_e             kind,
  output logic              is_long,
  output logic              is_byte,
  output logic              is_post,
  output logic [2:0]        amt
);
  logic size_ok, mode_ok, is_mem, align_ok;

  always_comb begin
    size_ok  = (size != 2'd3);
    mode_ok  = (mode == MD_DREG) || (mode == MD_AREG) || (mode == MD_IND) || (mode == MD_POST);
    is_mem   = (mode == MD_IND) || (mode == MD_POST);
    is_long  = (size == SZ_LONG);
    is_byte  = (size == SZ_BYTE);
    is_post  = (mode == MD_POST);
    align_ok = !is_mem || is_byte || !addr_lsb;
    valid    = size_ok && mode_ok && align_ok;
    if (is_mem)                          kind = K_MEM;
    else if (mode == MD_DREG && !is_long) kind = K_REG_SHORT;
    else                                 kind = K_REG_LONG;
    case (size)
      SZ_BYTE: amt = 3'd1;
      SZ_WORD: amt = 3'd2;
      default: amt = 3'd4;
    endcase
  end
endmodule

// File: rtl/quickop_fsm.sv
module quickop_fsm
  import quickop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  kind_e  new_kind,
  input  logic   new_long,
  input  kind_e  job_kind,
  input  logic   job_long,
  input  logic   job_post,
  input  logic   ack,
  output state_e state,
  output logic   operate,
  output logic   inc_req
);
  state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (accept) begin
        if (new_kind == K_MEM) nxt = new_long ? S_EACOPY : S_RDLO;
        else                   nxt = S_PF;
      end
      S_EACOPY: nxt = S_RDHI;
      S_RDHI:   if (ack) nxt = S_RDLO;
      S_RDLO:   if (ack) nxt = S_PF;
      S_PF:     if (ack) begin
        case (job_kind)
          K_REG_SHORT: nxt = S_IDLE;
          K_REG_LONG:  nxt = S_INT;
          default:     nxt = S_OPR;
        endcase
      end
      S_INT:    nxt = S_IDLE;
      S_OPR:    nxt = S_WRLO;
      S_WRLO:   if (ack) nxt = job_long ? S_WRHI : (job_post ? S_INC : S_IDLE);
      S_WRHI:   if (ack) nxt = job_post ? S_INC : S_IDLE;
      S_INC:    nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    operate = (state == S_OPR) || ((state == S_PF) && ack && (job_kind != K_MEM));
    inc_req = (state == S_INC);
  end
endmodule

// File: rtl/quickop_addr.sv
module quickop_addr
  import quickop_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  state_e            state,
  input  logic [ADDR_W-1:0] ea,
  input  logic              job_long,
  input  logic              job_byte,
  output logic [2:0]        step,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        lane
);
  localparam logic [ADDR_W-1:0] LOW_OFS = ADDR_W'(2);
  logic data_step, low_half;

  always_comb begin
    case (state)
      S_PF:    step = STEP_PREFETCH;
      S_INT:   step = STEP_INTERNAL;
      S_RDHI:  step = STEP_RD_HI;
      S_RDLO:  step = STEP_RD_LO;
      S_WRHI:  step = STEP_WR_HI;
      S_WRLO:  step = STEP_WR_LO;
      default: step = STEP_NONE;
    endcase
    data_step = (state == S_RDHI) || (state == S_RDLO) || (state == S_WRHI) || (state == S_WRLO);
    low_half  = job_long && ((state == S_RDLO) || (state == S_WRLO));
    addr      = low_half ? (ea + LOW_OFS) : ea;
    if (!data_step)    lane = 2'b00;
    else if (job_byte) lane = ea[0] ? 2'b01 : 2'b10;
    else               lane = 2'b11;
  end
endmodule

// File: rtl/quickop_seq.sv
module quickop_seq
  import quickop_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size,
  input  logic [2:0]        mode,
  input  logic [REG_W-1:0]  regno,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              ack,
  output logic              busy,
  output logic [2:0]        step,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        lane,
  output logic              operate,
  output logic              inc_req,
  output logic [REG_W-1:0]  inc_reg,
  output logic [2:0]        inc_amt,
  output logic              reject
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic       d_valid, d_long, d_byte, d_post;
  kind_e      d_kind;
  logic [2:0] d_amt;

  quickop_decode #(.ADDR_W(ADDR_W)) u_decode (
    .size(size), .mode(mode), .addr_lsb(base_addr[0]),
    .valid(d_valid), .kind(d_kind), .is_long(d_long), .is_byte(d_byte),
    .is_post(d_post), .amt(d_amt)
  );

  state_e state;
  logic   accept;

  assign busy   = (state != S_IDLE);
  assign accept = start && !busy && rst_sync_n && d_valid;
  assign reject = start && !busy && rst_sync_n && !d_valid;

  kind_e             job_kind;
  logic              job_long, job_byte, job_post;
  logic [ADDR_W-1:0] job_ea;
  logic [REG_W-1:0]  job_reg;
  logic [2:0]        job_amt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      job_kind <= K_REG_SHORT;
      job_long <= 1'b0;
      job_byte <= 1'b0;
      job_post <= 1'b0;
      job_ea   <= '0;
      job_reg  <= '0;
      job_amt  <= '0;
    end else if (accept) begin
      job_kind <= d_kind;
      job_long <= d_long;
      job_byte <= d_byte;
      job_post <= d_post;
      job_ea   <= base_addr;
      job_reg  <= regno;
      job_amt  <= d_amt;
    end
  end

  quickop_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .accept(accept),
    .new_kind(d_kind), .new_long(d_long),
    .job_kind(job_kind), .job_long(job_long), .job_post(job_post),
    .ack(ack), .state(state), .operate(operate), .inc_req(inc_req)
  );

  quickop_addr #(.ADDR_W(ADDR_W)) u_addr (
    .state(state), .ea(job_ea), .job_long(job_long), .job_byte(job_byte),
    .step(step), .addr(addr), .lane(lane)
  );

  assign inc_reg = job_reg;
  assign inc_amt = job_amt;
endmodule

// File: rtl/quickop_seq_chk.sv
module quickop_seq_chk
  import quickop_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ack,
  input logic              busy,
  input logic [2:0]        step,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        lane,
  input logic              operate,
  input logic              inc_req,
  input logic              reject
);
  logic bus_step, data_step;
  assign bus_step  = (step == STEP_PREFETCH) || (step == STEP_RD_HI) || (step == STEP_RD_LO) ||
                     (step == STEP_WR_HI) || (step == STEP_WR_LO);
  assign data_step = bus_step && (step != STEP_PREFETCH);

  AST_HOLD_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_step && !ack) |=> ((step == $past(step)) && (addr == $past(addr)))); // R7
  AST_INTERNAL_ENDS_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_INTERNAL) |=> !busy); // R2
  AST_INC_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inc_req |-> (($past(step) == STEP_WR_LO) || ($past(step) == STEP_WR_HI))); // R5
  AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !busy); // R6
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !reject) |=> busy); // R8
  AST_WIDE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (data_step && lane == 2'b11) |-> !addr[0]); // R9
  AST_DATA_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    data_step |-> (lane != 2'b00)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((step == STEP_NONE) && !operate && !inc_req)); // R10
endmodule

bind quickop_seq quickop_seq_chk #(.ADDR_W(ADDR_W)) u_quickop_seq_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .ack(ack), .busy(busy),
  .step(step), .addr(addr), .lane(lane), .operate(operate),
  .inc_req(inc_req), .reject(reject)
);

// File: tb/test_quickop_seq.sv
module test_quickop_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start, ack;
  logic [1:0]  size;
  logic [2:0]  mode, regno;
  logic [23:0] base_addr;
  logic        busy, operate, inc_req, reject;
  logic [2:0]  step, inc_reg, inc_amt;
  logic [23:0] addr;
  logic [1:0]  lane;

  quickop_seq i_quickop_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size), .mode(mode),
    .regno(regno), .base_addr(base_addr), .ack(ack), .busy(busy),
    .step(step), .addr(addr), .lane(lane), .operate(operate),
    .inc_req(inc_req), .inc_reg(inc_reg), .inc_amt(inc_amt), .reject(reject)
  );

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  logic [2:0]  e_step [0:7];
  logic [23:0] e_addr [0:7];
  logic        e_op   [0:7];
  logic        e_inc  [0:7];
  int          e_n;
  logic        e_valid;
  string       e_req;

  task automatic push(input logic [2:0] s, input logic [23:0] a, input logic op, input logic inc);
    e_step[e_n] = s; e_addr[e_n] = a; e_op[e_n] = op; e_inc[e_n] = inc; e_n++;
  endtask

  task automatic build_exp(input logic [1:0] sz, input logic [2:0] md, input logic [23:0] ba);
    logic mem;
    mem = (md == 3'd2) || (md == 3'd3);
    e_valid = (sz != 2'd3) && (md <= 3'd3) && !(mem && sz != 2'd0 && ba[0]);
    e_n = 0;
    if (!e_valid) return;
    if (md == 3'd0 && sz != 2'd2) begin
      e_req = "R1"; push(3'd1, ba, 1'b1, 1'b0);
    end else if (!mem) begin
      e_req = "R2"; push(3'd1, ba, 1'b1, 1'b0); push(3'd2, ba, 1'b0, 1'b0);
    end else if (sz != 2'd2) begin
      e_req = "R3";
      push(3'd4, ba, 0, 0); push(3'd1, ba, 0, 0); push(3'd0, ba, 1, 0); push(3'd6, ba, 0, 0);
    end else begin
      e_req = "R4";
      push(3'd0, ba, 0, 0); push(3'd5 - 3'd2, ba, 0, 0); push(3'd4, ba + 24'd2, 0, 0);
      push(3'd1, ba, 0, 0); push(3'd0, ba, 1, 0); push(3'd6, ba + 24'd2, 0, 0);
      push(3'd5, ba, 0, 0);
    end
    if (md == 3'd3) push(3'd0, ba, 1'b0, 1'b1);
  endtask

  task automatic run_job(input logic [1:0] sz, input logic [2:0] md, input logic [2:0] rg,
                         input logic [23:0] ba, input int prob, input bit inject);
    int  idx, cyc;
    bit  hold, bus, a;
    logic [2:0] hold_step;
    logic [1:0] e_lane;
    build_exp(sz, md, ba);
    e_lane = (sz == 2'd0) ? (ba[0] ? 2'b01 : 2'b10) : 2'b11;
    @(negedge clk);
    size = sz; mode = md; regno = rg; base_addr = ba; start = 1'b1; #1;
    chk("R6 reject flag", reject, !e_valid);
    @(negedge clk);
    start = 1'b0;
    if (!e_valid) begin
      chk("R6 busy after refused start", busy, 0);
      return;
    end
    chk("R8 busy after start", busy, 1);
    idx = 0; cyc = 0; hold = 0; hold_step = 0;
    while (idx < e_n && cyc < 100) begin
      cyc++;
      if (hold) chk("R7 step held", step, hold_step);
      bus = (step == 3'd1) || (step >= 3'd3 && step <= 3'd6);
      a = (($urandom % 100) < prob);
      ack = a;
      if (inject && cyc == 2) begin
        start = 1'b1; mode = 3'd0; size = 2'd0; base_addr = ~ba;
      end
      #1;
      if (inject && cyc == 2) chk("R8 start while busy", reject, 0);
      if (!bus || a) begin
        chk({e_req, " step order"}, step, e_step[idx]);
        chk({e_req, " operate"}, operate, e_op[idx]);
        chk("R5 inc request", inc_req, e_inc[idx]);
        if (e_step[idx] >= 3'd3) begin
          chk({e_req, " address"}, addr, e_addr[idx]);
          chk("R9 lane", lane, e_lane);
        end
        if (e_inc[idx]) begin
          chk("R5 inc reg", inc_reg, rg);
          chk("R5 inc amount", inc_amt, (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4);
        end
        idx++; hold = 0;
      end else begin
        hold = 1; hold_step = step;
      end
      @(negedge clk);
      start = 1'b0; ack = 1'b0;
    end
    chk("R8 job completes", idx, e_n);
    chk("R8 busy drops", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; ack = 1'b0; size = 0; mode = 0; regno = 0; base_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 step", step, 0);
    chk("R10 operate", operate, 0);
    chk("R10 inc", inc_req, 0);
    // directed cases
    run_job(2'd0, 3'd0, 3'd1, 24'h000100, 100, 0); // R1
    run_job(2'd1, 3'd0, 3'd2, 24'h000100, 50, 0);  // R1
    run_job(2'd2, 3'd0, 3'd3, 24'h000100, 50, 0);  // R2
    run_job(2'd0, 3'd1, 3'd4, 24'h000100, 30, 0);  // R2
    run_job(2'd1, 3'd2, 3'd5, 24'h001000, 50, 0);  // R3
    run_job(2'd0, 3'd3, 3'd6, 24'h001001, 50, 0);  // R3 R5 R9 odd byte
    run_job(2'd0, 3'd2, 3'd6, 24'h001002, 100, 0); // R9 even byte
    run_job(2'd2, 3'd2, 3'd7, 24'hFFFFFE, 50, 0);  // R4 wrap
    run_job(2'd2, 3'd3, 3'd0, 24'h123456, 40, 1);  // R4 R5 R8
    run_job(2'd1, 3'd3, 3'd2, 24'h00ABCE, 20, 1);  // R5 R7
    run_job(2'd1, 3'd2, 3'd2, 24'h000003, 50, 0);  // R6 odd word
    run_job(2'd3, 3'd0, 3'd2, 24'h000000, 50, 0);  // R6 size
    run_job(2'd0, 3'd5, 3'd2, 24'h000000, 50, 0);  // R6 mode
    // random
    for (int i = 0; i < 60; i++) begin
      run_job(2'($urandom % 4), 3'($urandom % 8), 3'($urandom), 24'($urandom),
              20 + int'($urandom % 80), bit'($urandom % 2));
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got %0d expected below 150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule